// File: doc/BRIEF.md
# Instruction Cycle Accounting Counter

This block keeps performance statistics for a processor core. The core sends one retire event for each instruction it completes. Each event carries a three-bit instruction class, a branch-taken flag and a delay-slot flag. The block counts the retired instructions. It also builds an estimated cycle total by adding a fixed cost for each event, and that cost depends only on the class and the two flags.

The readout shows the instruction count as it stands. It shows the cycle total as a reported value: the accumulated count plus two, or zero while nothing has been accumulated. A clear input returns both counters to zero. Both counters stop at their all-ones value instead of wrapping.

Top module: `instr_cycle_acct`

## Requirements
- R1: After reset, both `inst_count` and `cycle_report` read zero.
- R2: A cycle with `retire_valid` high (and no clear) raises `inst_count` by one at the next clock edge. A cycle with neither retire nor clear leaves both outputs unchanged.
- R3: Class 0 (plain ALU) costs one cycle. Class 7 (branch or return) also costs one cycle when `branch_taken` is low, whatever the delay-slot flag says.
- R4: Class 1 (load) and class 2 (store) each cost two cycles.
- R5: Class 3 (multiply), class 4 (barrel shift) and class 5 (custom extension) each cost two cycles.
- R6: Class 6 (divide) costs 34 cycles: one base cycle and 33 extra.
- R7: A taken class 7 event costs two cycles when `has_delay_slot` is high and three when it is low. For classes 0 to 6 the two flags have no effect on the cost.
- R8: `cycle_report` is zero while the accumulated cycle count is zero. Otherwise it is the accumulated count plus two, limited to the all-ones value.
- R9: A cycle with `clear` high zeroes both counters at the next edge.
- R10: When `clear` and `retire_valid` are high in the same cycle, the clear wins and the retire event is lost.
- R11: Both counters saturate at their all-ones value and never wrap. Further events leave them there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_valid | input | 1 | One instruction retires this cycle |
| retire_class | input | 3 | Class of the retiring instruction (0 ALU, 1 load, 2 store, 3 multiply, 4 shift, 5 extension, 6 divide, 7 branch/return) |
| branch_taken | input | 1 | The retiring branch was taken |
| has_delay_slot | input | 1 | The retiring branch has a delay slot |
| clear | input | 1 | Zero both counters |
| inst_count | output | CNT_W | Retired-instruction count |
| cycle_report | output | CNT_W | Reported cycle total |

## Verification
A clear and a retire event can arrive in the same cycle. The bench drives both together on several classes, including a divide, and expects both outputs to read zero one edge later. A retire event can also arrive while a counter is already saturated. To reach that quickly, the bench builds the block with 8-bit counters and runs it past saturation with divides and long ALU runs. A behavioural model checks every clock that each counter holds at all-ones and that the reported value is clamped rather than wrapped.

// File: rtl/instr_cycle_acct.sv
module instr_cycle_acct #(
  parameter int CNT_W     = 32,
  parameter int DIV_EXTRA = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_valid,
  input  logic [2:0]       retire_class,
  input  logic             branch_taken,
  input  logic             has_delay_slot,
  input  logic             clear,
  output logic [CNT_W-1:0] inst_count,
  output logic [CNT_W-1:0] cycle_report
);

  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   OFFSET = (CNT_W+1)'(2);

  logic [CNT_W-1:0] inst_q, cyc_q, cost;
  logic [CNT_W:0]   cyc_sum, rep_sum;

  always_comb begin
    case (retire_class)
      3'd0:                cost = CNT_W'(1);
      3'd1, 3'd2:          cost = CNT_W'(2);
      3'd3, 3'd4, 3'd5:    cost = CNT_W'(2);
      3'd6:                cost = CNT_W'(1 + DIV_EXTRA);
      default: begin
        if (!branch_taken)       cost = CNT_W'(1);
        else if (has_delay_slot) cost = CNT_W'(2);
        else                     cost = CNT_W'(3);
      end
    endcase
  end

  assign cyc_sum = {1'b0, cyc_q} + {1'b0, cost};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      inst_q <= '0;
      cyc_q  <= '0;
    end else if (retire_valid) begin
      if (inst_q != MAX_V) inst_q <= inst_q + 1'b1;
      cyc_q <= cyc_sum[CNT_W] ? MAX_V : cyc_sum[CNT_W-1:0];
    end
  end

  assign rep_sum      = {1'b0, cyc_q} + OFFSET;
  assign inst_count   = inst_q;
  assign cycle_report = (cyc_q == '0) ? '0
                      : (rep_sum[CNT_W] ? MAX_V : rep_sum[CNT_W-1:0]);

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (inst_count == '0 && cycle_report == '0));

  // R2
  inst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !clear && inst_q != MAX_V) |=> inst_q == CNT_W'($past(inst_q) + 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_valid && !clear) |=> ($stable(inst_q) && $stable(cyc_q)));

  // R11
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (inst_q >= $past(inst_q) && cyc_q >= $past(cyc_q)));

  // R6
  div_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !clear && retire_class == 3'd6 && cyc_q == '0)
      |=> cyc_q == CNT_W'(1 + DIV_EXTRA));

  // R8
  report_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == '0) |-> (cycle_report == '0));

endmodule

// File: tb/instr_cycle_acct_test.sv
module instr_cycle_acct_test;
  localparam int W = 8;
  localparam int MAXI = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic retire_valid = 0, branch_taken = 0, has_delay_slot = 0, clear = 0;
  logic [2:0] retire_class = 0;
  logic [W-1:0] inst_count, cycle_report;

  int checks = 0, failures = 0;
  int m_inst = 0, m_cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  instr_cycle_acct #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid),
    .retire_class(retire_class), .branch_taken(branch_taken),
    .has_delay_slot(has_delay_slot), .clear(clear),
    .inst_count(inst_count), .cycle_report(cycle_report));

  function automatic int cost_of(int c, bit tk, bit ds);
    if (c == 6) return 34;
    if (c >= 1 && c <= 5) return 2;
    if (c == 7 && tk) return ds ? 2 : 3;
    return 1;
  endfunction

  function automatic int rep_of(int acc);
    if (acc == 0) return 0;
    return (acc + 2 > MAXI) ? MAXI : acc + 2;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (inst_count !== W'(m_inst) || cycle_report !== W'(rep_of(m_cyc))) begin
      failures++;
      $display("FAIL %s: inst=%0d cyc_rep=%0d expected inst=%0d cyc_rep=%0d",
               tag, inst_count, cycle_report, m_inst, rep_of(m_cyc));
    end
  endtask

  task automatic step(bit v, int c, bit tk, bit ds, bit clr, string tag);
    retire_valid = v; retire_class = 3'(c); branch_taken = tk;
    has_delay_slot = ds; clear = clr;
    @(posedge clk);
    if (clr) begin m_inst = 0; m_cyc = 0; end
    else if (v) begin
      if (m_inst < MAXI) m_inst++;
      m_cyc = m_cyc + cost_of(c, tk, ds);
      if (m_cyc > MAXI) m_cyc = MAXI;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    step(0, 0, 0, 0, 0, "R1 idle after reset");
    step(1, 0, 1, 1, 0, "R3 alu with flags R7");
    step(0, 0, 0, 0, 0, "R2 idle hold");
    step(1, 7, 0, 0, 0, "R3 branch not taken");
    step(1, 7, 0, 1, 0, "R3 branch not taken ds");
    step(1, 1, 0, 0, 0, "R4 load");
    step(1, 2, 1, 0, 0, "R4 store");
    step(1, 3, 0, 0, 0, "R5 multiply");
    step(1, 4, 1, 1, 0, "R5 shift");
    step(1, 5, 0, 0, 0, "R5 extension");
    step(1, 7, 1, 1, 0, "R7 taken with slot");
    step(1, 7, 1, 0, 0, "R7 taken no slot");
    step(0, 0, 0, 0, 1, "R9 clear");
    step(1, 6, 1, 0, 0, "R6 divide R8");
    step(0, 0, 0, 0, 1, "R9 clear again");
    step(1, 6, 0, 0, 1, "R10 clear beats divide");
    step(1, 0, 0, 0, 1, "R10 clear beats alu");
    step(1, 0, 0, 0, 0, "R8 report offset");
    for (int i = 0; i < 9; i++) step(1, 6, 0, 0, 0, "R11 cycle saturation");
    step(1, 7, 1, 0, 0, "R11 cycle held at max");
    for (int i = 0; i < 250; i++) step(1, i % 8, i[0], i[1], 0, "R2 mixed run");
    step(1, 0, 0, 0, 0, "R11 inst held at max");
    step(0, 0, 0, 0, 1, "R9 clear after saturation");
    step(0, 0, 0, 0, 0, "R1 zero report");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule